// File: doc/BRIEF.md
# Four-Stage Shift Register with J/K-Bar Serial Entry

This block holds four bits in a chain of clocked stages. On every rising clock edge it does one of two things, chosen by a mode input. It either shifts the chain one place toward the last stage, or it captures four parallel data bits into all stages at once. During a shift, the bit entering the first stage comes from a J/K-bar rule. That rule can clear, set, hold or toggle the first stage. When J and K-bar are driven together, they behave as an ordinary serial data input.

An active-high master reset clears the stored bits at once, with no clock needed. A polarity select chooses whether the output pins show the stored bits or their inverses. This select acts combinationally, with no clock needed. A designer can build shift-left behaviour, ring counters or Johnson counters around the block by wiring its outputs back into its parallel inputs.

Top module: `jkshr_top`

## Requirements
- R1: While `rst` is 1, every stored bit is 0. Reset takes effect at once, with no clock edge, and it overrides both the load action and the shift action.
- R2: On a rising edge with `load_en` = 1, stored bit i becomes `par_d[i]` for every i.
- R3: On a rising edge with `load_en` = 0, stored bit i (for i from 1 to 3) becomes the old value of bit i-1. Data moves from bit 0 toward bit 3.
- R4: During a shift with `j_in` = 0 and `kn_in` = 0, the new bit 0 is 0.
- R5: During a shift with `j_in` = 1 and `kn_in` = 1, the new bit 0 is 1.
- R6: During a shift with `j_in` = 0 and `kn_in` = 1, bit 0 keeps its old value.
- R7: During a shift with `j_in` = 1 and `kn_in` = 0, bit 0 becomes the inverse of its old value.
- R8: With `true_sel` = 1, `q_out[i]` equals stored bit i. With `true_sel` = 0, `q_out[i]` equals the inverse of stored bit i. A change of `true_sel` reaches the outputs with no clock edge.
- R9: Reset clears only the stored bits. After a reset with `true_sel` = 0, `q_out` reads 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst | input | 1 | Asynchronous master reset, active high |
| load_en | input | 1 | 1 = parallel capture, 0 = shift toward bit 3 |
| j_in | input | 1 | J term of the first-stage rule |
| kn_in | input | 1 | Inverted-K term of the first-stage rule |
| par_d | input | 4 | Parallel data; bit i goes to stage i |
| true_sel | input | 1 | 1 = outputs show stored bits, 0 = inverted |
| q_out | output | 4 | Stage outputs after the polarity select |

## Verification
On every clock, the assertions recover the stored bits from `q_out` and `true_sel`. From those bits they check the reset-clears rule, parallel capture, the one-place shift and each of the four J/K-bar entry rules. Some behaviour can only be shown by the bench's scenarios: the outputs changing between clock edges when the polarity select flips, reset hitting mid-cycle and holding across a load edge, and the all-ones reading after a reset in complement mode. Each of these scenarios is compared against a behavioural reference model on every cycle.

// File: rtl/jkshr_pkg.sv
package jkshr_pkg;

    localparam int unsigned JKSHR_STAGES = 4;

    // Action selected by {j, kn} for the first stage
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_act_e;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } shr_mode_e;

endpackage

// File: rtl/jkshr_entry.sv
module jkshr_entry
    import jkshr_pkg::*;
(
    input  logic j,
    input  logic kn,
    input  logic cur,
    output logic nxt
);
    jk_act_e act;

    always_comb begin
        act = jk_act_e'({j, kn});
        unique case (act)
            JK_CLEAR:  nxt = 1'b0;
            JK_HOLD:   nxt = cur;
            JK_TOGGLE: nxt = ~cur;
            JK_SET:    nxt = 1'b1;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/jkshr_core.sv
module jkshr_core
    import jkshr_pkg::*;
#(
    parameter int unsigned W = JKSHR_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] par_d,
    input  logic         head_d,
    output logic [W-1:0] stg_q
);
    typedef struct packed {
        logic [W-1:0] stg;
    } core_t;

    core_t cs_d, cs_q;
    shr_mode_e mode;

    always_comb begin
        mode = shr_mode_e'(load_en);
        cs_d = cs_q;
        if (mode == MODE_LOAD) begin
            cs_d.stg = par_d;
        end else begin
            cs_d.stg = {cs_q.stg[W-2:0], head_d};
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign stg_q = cs_q.stg;
endmodule

// File: rtl/jkshr_polarity.sv
module jkshr_polarity #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] stg,
    input  logic         true_sel,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = true_sel ? stg[i] : ~stg[i];
    end
endmodule

// File: rtl/jkshr_top.sv
module jkshr_top
    import jkshr_pkg::*;
#(
    parameter int unsigned W = JKSHR_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         j_in,
    input  logic         kn_in,
    input  logic [W-1:0] par_d,
    input  logic         true_sel,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stg_q;
    logic         head_d;

    jkshr_entry u_entry (
        .j   (j_in),
        .kn  (kn_in),
        .cur (stg_q[0]),
        .nxt (head_d)
    );

    jkshr_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .par_d   (par_d),
        .head_d  (head_d),
        .stg_q   (stg_q)
    );

    jkshr_polarity #(.W(W)) u_pol (
        .stg      (stg_q),
        .true_sel (true_sel),
        .q        (q_out)
    );
endmodule

// File: rtl/jkshr_chk.sv
module jkshr_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_en,
    input logic         j_in,
    input logic         kn_in,
    input logic [W-1:0] par_d,
    input logic         true_sel,
    input logic [W-1:0] q_out
);
    logic [W-1:0] stg_v;
    assign stg_v = true_sel ? q_out : ~q_out;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |-> stg_v == '0);

    // R2
    a_r2_parallel_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> stg_v == $past(par_d));

    // R3
    a_r3_shift_chain: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> stg_v[W-1:1] == $past(stg_v[W-2:0]));

    // R4
    a_r4_entry_clear: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !j_in && !kn_in) |=> !stg_v[0]);

    // R5
    a_r5_entry_set: assert property (@(posedge clk) disable iff (rst)
        (!load_en && j_in && kn_in) |=> stg_v[0]);

    // R6
    a_r6_entry_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !j_in && kn_in) |=> stg_v[0] == $past(stg_v[0]));

    // R7
    a_r7_entry_toggle: assert property (@(posedge clk) disable iff (rst)
        (!load_en && j_in && !kn_in) |=> stg_v[0] != $past(stg_v[0]));
endmodule

bind jkshr_top jkshr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .j_in     (j_in),
    .kn_in    (kn_in),
    .par_d    (par_d),
    .true_sel (true_sel),
    .q_out    (q_out)
);

// File: tb/jkshr_top_tb.sv
`timescale 1ns/1ps
module jkshr_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic       j_in = 1'b0;
    logic       kn_in = 1'b0;
    logic [3:0] par_d = 4'h0;
    logic       true_sel = 1'b1;
    logic [3:0] q_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model [4];

    always #4 clk = ~clk;

    jkshr_top u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .j_in(j_in),
        .kn_in(kn_in), .par_d(par_d), .true_sel(true_sel), .q_out(q_out)
    );

    function automatic logic [3:0] expect_q();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = true_sel ? model[i] : !model[i];
        return v;
    endfunction

    task automatic check(string req);
        logic [3:0] e;
        e = expect_q();
        checks++;
        if (q_out !== e) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, q_out, e);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 4; i++) model[i] = 0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(bit l, bit j, bit kn, logic [3:0] d, string req);
        bit head;
        load_en = l; j_in = j; kn_in = kn; par_d = d;
        @(posedge clk);
        if (l) begin
            for (int i = 0; i < 4; i++) model[i] = d[i];
        end else begin
            if (!j && !kn)     head = 0;
            else if (j && kn)  head = 1;
            else if (!j && kn) head = model[0];
            else               head = !model[0];
            for (int i = 3; i > 0; i--) model[i] = model[i-1];
            model[0] = head;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        @(negedge clk); @(negedge clk);
        check("R1 reset state");
        true_sel = 1'b0; #1;
        check("R9 reset complement all ones");
        true_sel = 1'b1; #1;
        rst = 1'b0;

        // parallel load then four shifts
        cyc(1, 0, 0, 4'b1011, "R2 load");
        cyc(0, 1, 1, 4'h0, "R5 set entry R3");
        cyc(0, 0, 0, 4'h0, "R4 clear entry R3");
        cyc(0, 1, 1, 4'h0, "R5 set entry R3");
        cyc(0, 0, 0, 4'h0, "R4 clear entry R3");

        // hold and toggle
        cyc(0, 1, 1, 4'h0, "R5 prime");
        cyc(0, 0, 1, 4'h0, "R6 hold");
        cyc(0, 0, 1, 4'h0, "R6 hold again");
        cyc(0, 1, 0, 4'h0, "R7 toggle");
        cyc(0, 1, 0, 4'h0, "R7 toggle");
        cyc(0, 1, 0, 4'h0, "R7 toggle");

        // polarity flip with no clock edge between
        #1; true_sel = 1'b0; #1;
        check("R8 complement between edges");
        true_sel = 1'b1; #1;
        check("R8 true between edges");
        @(negedge clk);

        // mid-cycle reset that overrides a load edge
        cyc(1, 0, 0, 4'b1111, "R2 load ones");
        #2; rst = 1'b1; #1;
        clear_model();
        check("R1 async reset mid-cycle");
        load_en = 1'b1; par_d = 4'b1010;
        @(negedge clk);
        check("R1 reset overrides load");
        rst = 1'b0;

        // complement mode operation
        true_sel = 1'b0;
        cyc(1, 0, 0, 4'b0110, "R8 R2 load complement");
        cyc(0, 1, 0, 4'h0, "R8 R7 toggle complement");
        cyc(0, 0, 1, 4'h0, "R8 R6 hold complement");
        true_sel = 1'b1;

        // varied pattern sweep
        for (int i = 0; i < 24; i++) begin
            logic [4:0] s;
            s = 5'(i * 7 + 3);
            cyc(s[4] & s[0], s[1], s[2], 4'(i * 5), "R3 sweep");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule